// File: doc/BRIEF.md
# Segment LCD Phase and Blink Sequencer

This block produces the digital multiplexing pattern for a segment LCD with up to 64 pins. A frame tick input steps a phase counter through 1 to 8 phases, the number chosen by a 3-bit duty field. Each pin owns an 8-bit waveform byte, loaded through a single-cycle write port. Bit 0 of the byte belongs to the first phase and bit 7 to the eighth. In every cycle the block reports, for each pin, whether that pin is active in the current phase and whether it serves as a backplane. An analog driver outside the block turns that information into bias voltages.

Three display views are available: normal, alternate and blank. The alternate view reads the upper half of each waveform byte, so it is valid only with four phases or fewer. A blink timer switches between a shown half and a hidden half. In the hidden half the block shows either the blank view or the alternate view. The phase sequencer is a two-state machine: `SEQ_OFF` (controller disabled, phase held at 0) and `SEQ_RUN` (ticks advance the phase). `SEQ_OFF` goes to `SEQ_RUN` when `ctrl_en` is seen high, and `SEQ_RUN` goes back to `SEQ_OFF` when it is seen low. The blink timer is a second two-state machine: `BLK_SHOW` and `BLK_HIDE`. It swaps between the two each time its counter reaches the end of a half period, and it goes straight back to `BLK_SHOW`, with the counter cleared, whenever blinking or the controller is switched off.

Top module: `seglcd_seq`

## Requirements
- R1: After reset the phase index is 0, `frame_start` is low, every waveform byte is 0 and every `pin_active` bit is 0.
- R2: With `duty` = d, each cycle in which `frame_tick` is high while running moves `phase_idx` from p to p+1, or to 0 when p ≥ d. Without a tick the phase holds.
- R3: `frame_start` is high for exactly the cycle after a tick that wraps the phase back to 0, so it coincides with `phase_idx` = 0.
- R4: In the normal view an enabled pin is active when bit `phase_idx` of its byte is set (bit 0 = first phase, bit 7 = eighth). A write through `wr_en`/`wr_addr`/`wr_data` takes effect from the next cycle.
- R5: A pin with `pin_en` low is never active. `pin_role` equals `pin_en & pin_bp`, where 1 means backplane.
- R6: While `ctrl_en` is low, every `pin_active` bit is 0 in that same cycle, ticks are ignored, and the phase returns to 0 at the next edge.
- R7: `disp_mode` 2 (and the unused code 3) selects the blank view. Backplane pins follow bit `phase_idx` of their byte, and frontplane pins are inactive.
- R8: `disp_mode` 1 selects the alternate view when `duty` ≤ 3. Every enabled pin then follows bit `phase_idx`+4 of its byte. With `duty` ≥ 4, mode 1 gives the blank view instead.
- R9: While `blink_en` is high, the display is shown for 2^(BLINK_BASE+`blink_rate`) cycles, then hidden for the same count, and so on, with the count starting at the first cycle `blink_en` is seen high.
- R10: In the hidden half, `blink_mode` 0 gives the blank view. `blink_mode` 1 gives the alternate view when `duty` ≤ 3 and the blank view otherwise.
- R11: Clearing `blink_en` restores the `disp_mode` view in the same cycle and restarts the blink count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the LCD time base for blinking |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| frame_tick | input | 1 | Advance to the next phase |
| duty | input | 3 | Number of phases minus one |
| disp_mode | input | 2 | 0 normal, 1 alternate, 2/3 blank |
| blink_en | input | 1 | Blink timer enable |
| blink_mode | input | 1 | Hidden half: 0 blank, 1 alternate |
| blink_rate | input | RATE_W | Half-period exponent offset |
| pin_en | input | NPIN | Per-pin enable |
| pin_bp | input | NPIN | Per-pin backplane marker |
| wr_en | input | 1 | Waveform byte write strobe |
| wr_addr | input | $clog2(NPIN) | Pin index to write |
| wr_data | input | 8 | Waveform byte |
| pin_active | output | NPIN | Pin active in current phase |
| pin_role | output | NPIN | Pin is an enabled backplane |
| phase_idx | output | 3 | Current phase index |
| frame_start | output | 1 | Frame wrap pulse |

## Verification
Two events can land on the same clock edge: a phase advance and the blink timer entering its hidden half. The bench arranges for a frame tick on exactly the edge at which the blink count expires. Immediately afterwards it checks that the pins show the blank view at the new phase, not the old phase in either view. A second collision is a waveform byte written while a phase is being displayed. The bench judges that case at the port on the following cycle.

// File: rtl/seglcd_pkg.sv
package seglcd_pkg;
    localparam int PHASES  = 8;
    localparam int PH_W    = $clog2(PHASES);
    localparam int ALT_OFS = PHASES / 2;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_ALT    = 2'd1;

    typedef enum logic [1:0] {
        VIEW_NORMAL = 2'd0,
        VIEW_ALT    = 2'd1,
        VIEW_BLANK  = 2'd2
    } view_e;

    typedef enum logic {
        SEQ_OFF = 1'b0,
        SEQ_RUN = 1'b1
    } seq_state_e;

    typedef enum logic {
        BLK_SHOW = 1'b0,
        BLK_HIDE = 1'b1
    } blk_state_e;
endpackage

// File: rtl/seglcd_wfmem.sv
module seglcd_wfmem
    import seglcd_pkg::*;
#(
    parameter int NPIN   = 64,
    parameter int ADDR_W = $clog2(NPIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [PHASES-1:0]             wr_data,
    output logic [NPIN-1:0][PHASES-1:0]   wf
);
    for (genvar i = 0; i < NPIN; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wf[i] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                wf[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/seglcd_phase_fsm.sv
module seglcd_phase_fsm
    import seglcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_en,
    input  logic            frame_tick,
    input  logic [PH_W-1:0] duty,
    output logic [PH_W-1:0] phase,
    output logic            frame_start
);
    seq_state_e      state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic            fs_q;
    logic            advance;
    logic            at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF: if (ctrl_en)  state_d = SEQ_RUN;
            SEQ_RUN: if (!ctrl_en) state_d = SEQ_OFF;
            default: state_d = SEQ_OFF;
        endcase
    end

    assign advance = (state_q == SEQ_RUN) && ctrl_en && frame_tick;
    assign at_last = (phase_q >= duty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            fs_q    <= 1'b0;
        end else if (!ctrl_en) begin
            phase_q <= '0;
            fs_q    <= 1'b0;
        end else if (advance) begin
            phase_q <= at_last ? '0 : phase_q + 1'b1;
            fs_q    <= at_last;
        end else begin
            fs_q    <= 1'b0;
        end
    end

    always_comb begin
        phase       = phase_q;
        frame_start = fs_q;
    end
endmodule

// File: rtl/seglcd_blink_fsm.sv
module seglcd_blink_fsm
    import seglcd_pkg::*;
#(
    parameter int BLINK_BASE = 12,
    parameter int RATE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              hide
);
    localparam int CNT_W = BLINK_BASE + (1 << RATE_W) - 1;

    blk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             expire;

    assign limit  = ~({CNT_W{1'b1}} << (BLINK_BASE + int'(rate)));
    assign expire = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BLK_SHOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_SHOW: if (!run) state_d = BLK_SHOW; else if (expire) state_d = BLK_HIDE;
            BLK_HIDE: if (!run) state_d = BLK_SHOW; else if (expire) state_d = BLK_SHOW;
            default:  state_d = BLK_SHOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (expire) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        hide = run && (state_q == BLK_HIDE);
    end
endmodule

// File: rtl/seglcd_pin_map.sv
module seglcd_pin_map
    import seglcd_pkg::*;
#(
    parameter int NPIN = 64
) (
    input  logic                        en,
    input  view_e                       view,
    input  logic [PH_W-1:0]             phase,
    input  logic [NPIN-1:0][PHASES-1:0] wf,
    input  logic [NPIN-1:0]             pin_en,
    input  logic [NPIN-1:0]             pin_bp,
    output logic [NPIN-1:0]             pin_active,
    output logic [NPIN-1:0]             pin_role
);
    logic [PH_W:0] alt_idx;
    assign alt_idx = {1'b0, phase} + (PH_W+1)'(ALT_OFS);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic lo_bit, hi_bit, sel;

        assign lo_bit = wf[i][phase];
        assign hi_bit = alt_idx[PH_W] ? 1'b0 : wf[i][alt_idx[PH_W-1:0]];

        always_comb begin
            unique case (view)
                VIEW_NORMAL: sel = lo_bit;
                VIEW_ALT:    sel = hi_bit;
                VIEW_BLANK:  sel = pin_bp[i] & lo_bit;
                default:     sel = 1'b0;
            endcase
        end

        assign pin_active[i] = en & pin_en[i] & sel;
        assign pin_role[i]   = pin_en[i] & pin_bp[i];
    end
endmodule

// File: rtl/seglcd_seq.sv
module seglcd_seq
    import seglcd_pkg::*;
#(
    parameter int NPIN       = 64,
    parameter int BLINK_BASE = 12,
    parameter int RATE_W     = 3,
    localparam int ADDR_W    = $clog2(NPIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              frame_tick,
    input  logic [2:0]        duty,
    input  logic [1:0]        disp_mode,
    input  logic              blink_en,
    input  logic              blink_mode,
    input  logic [RATE_W-1:0] blink_rate,
    input  logic [NPIN-1:0]   pin_en,
    input  logic [NPIN-1:0]   pin_bp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NPIN-1:0]   pin_active,
    output logic [NPIN-1:0]   pin_role,
    output logic [2:0]        phase_idx,
    output logic              frame_start
);
    logic [NPIN-1:0][PHASES-1:0] wf;
    logic                        hide;
    logic                        alt_ok;
    view_e                       view;

    seglcd_wfmem #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wf(wf)
    );

    seglcd_phase_fsm u_phase (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .frame_tick(frame_tick),
        .duty(duty), .phase(phase_idx), .frame_start(frame_start)
    );

    seglcd_blink_fsm #(.BLINK_BASE(BLINK_BASE), .RATE_W(RATE_W)) u_blink (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en & blink_en),
        .rate(blink_rate), .hide(hide)
    );

    assign alt_ok = (duty < PH_W'(ALT_OFS));

    always_comb begin
        if (hide) begin
            view = (blink_mode && alt_ok) ? VIEW_ALT : VIEW_BLANK;
        end else if (disp_mode == MODE_NORMAL) begin
            view = VIEW_NORMAL;
        end else if (disp_mode == MODE_ALT) begin
            view = alt_ok ? VIEW_ALT : VIEW_BLANK;
        end else begin
            view = VIEW_BLANK;
        end
    end

    seglcd_pin_map #(.NPIN(NPIN)) u_map (
        .en(ctrl_en), .view(view), .phase(phase_idx), .wf(wf),
        .pin_en(pin_en), .pin_bp(pin_bp),
        .pin_active(pin_active), .pin_role(pin_role)
    );
endmodule

// File: rtl/seglcd_seq_chk.sv
module seglcd_seq_chk #(
    parameter int NPIN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_en,
    input logic            frame_tick,
    input logic [2:0]      duty,
    input logic [1:0]      disp_mode,
    input logic            blink_en,
    input logic [NPIN-1:0] pin_en,
    input logic [NPIN-1:0] pin_bp,
    input logic [NPIN-1:0] pin_active,
    input logic [2:0]      phase_idx,
    input logic            frame_start
);
    // R3
    wrap_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> phase_idx == 3'd0);

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !frame_tick) |=> $stable(phase_idx));

    // R6
    off_phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> phase_idx == 3'd0);

    // R6
    off_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> pin_active == '0);

    // R5
    disabled_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_active & ~pin_en) == '0);

    // R7
    blank_front_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode == 2'd2 && !blink_en) |-> (pin_active & ~pin_bp) == '0);

    // R8
    alt_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode == 2'd1 && duty > 3'd3 && !blink_en) |-> (pin_active & ~pin_bp) == '0);
endmodule

bind seglcd_seq seglcd_seq_chk #(.NPIN(NPIN)) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .frame_tick(frame_tick),
    .duty(duty), .disp_mode(disp_mode), .blink_en(blink_en),
    .pin_en(pin_en), .pin_bp(pin_bp), .pin_active(pin_active),
    .phase_idx(phase_idx), .frame_start(frame_start)
);

// File: tb/test_seglcd_seq.sv
module test_seglcd_seq;
    localparam int NP = 8;
    localparam int BB = 3;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctrl_en, frame_tick, blink_en, blink_mode, wr_en;
    logic [2:0]    duty, blink_rate;
    logic [1:0]    disp_mode;
    logic [NP-1:0] pin_en, pin_bp, pin_active, pin_role;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [2:0]    phase_idx;
    logic          frame_start;

    logic [7:0] bytes_m [NP];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int ph;

    always #5 clk = ~clk;

    seglcd_seq #(.NPIN(NP), .BLINK_BASE(BB), .RATE_W(3)) i_seglcd_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .frame_tick(frame_tick),
        .duty(duty), .disp_mode(disp_mode), .blink_en(blink_en),
        .blink_mode(blink_mode), .blink_rate(blink_rate), .pin_en(pin_en),
        .pin_bp(pin_bp), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_active(pin_active), .pin_role(pin_role), .phase_idx(phase_idx),
        .frame_start(frame_start)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // view codes: 0 normal, 1 alternate, 2 blank
    function automatic int exp_view(int mode, int d, bit hide, bit bm);
        if (hide) return (bm && d < 4) ? 1 : 2;
        if (mode == 0) return 0;
        if (mode == 1) return (d < 4) ? 1 : 2;
        return 2;
    endfunction

    function automatic logic [NP-1:0] exp_vec(int p_ph, int view, bit en);
        logic [NP-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            if (en && pin_en[p]) begin
                if (view == 0)      v[p] = bytes_m[p][p_ph];
                else if (view == 1) v[p] = (p_ph + 4 < 8) ? bytes_m[p][p_ph + 4] : 1'b0;
                else                v[p] = pin_bp[p] & bytes_m[p][p_ph];
            end
        end
        return v;
    endfunction

    task automatic wr(int a, logic [7:0] v);
        wr_en = 1; wr_addr = AW'(a); wr_data = v;
        @(negedge clk);
        wr_en = 0;
        bytes_m[a] = v;
    endtask

    task automatic tick();
        frame_tick = 1;
        @(negedge clk);
        frame_tick = 0;
    endtask

    task automatic restart(int d, int mode);
        ctrl_en = 0; duty = 3'(d); disp_mode = 2'(mode);
        @(negedge clk);
        ctrl_en = 1;
        @(negedge clk);
        ph = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; ctrl_en = 0; frame_tick = 0; blink_en = 0; blink_mode = 0;
        wr_en = 0; duty = 0; blink_rate = 0; disp_mode = 0; pin_en = '0;
        pin_bp = '0; wr_addr = '0; wr_data = '0;
        for (int p = 0; p < NP; p++) bytes_m[p] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 phase", 64'(phase_idx), 0);
        chk("R1 frame_start", 64'(frame_start), 0);
        chk("R1 pins", 64'(pin_active), 0);
        rst_n = 1;
        @(negedge clk);
        ctrl_en = 1; pin_en = '1;
        @(negedge clk);
        chk("R1 bytes zero", 64'(pin_active), 0);
        ctrl_en = 0;

        pin_en = 8'b1110_1111;
        pin_bp = 8'b0000_0011;
        for (int p = 0; p < NP; p++) wr(p, 8'((p * 53 + 29) & 255));
        chk("R5 role", 64'(pin_role), 64'(pin_en & pin_bp));

        for (int mode = 0; mode < 4; mode++) begin
            for (int d = 0; d < 8; d++) begin
                ctrl_en = 0; duty = 3'(d); disp_mode = 2'(mode);
                tick();
                chk("R6 off phase", 64'(phase_idx), 0);
                chk("R6 off pins", 64'(pin_active), 0);
                ctrl_en = 1;
                @(negedge clk);
                ph = 0;
                chk(mode == 0 ? "R4 R5 pins" : (mode == 1 ? "R8 pins" : "R7 pins"),
                    64'(pin_active), 64'(exp_vec(ph, exp_view(mode, d, 0, 0), 1)));
                for (int k = 0; k < 2 * (d + 1); k++) begin
                    bit wrap;
                    tick();
                    wrap = (ph == d);
                    ph = wrap ? 0 : ph + 1;
                    chk("R2 phase", 64'(phase_idx), 64'(ph));
                    chk("R3 frame_start", 64'(frame_start), 64'(wrap));
                    chk(mode == 0 ? "R4 R5 pins" : (mode == 1 ? "R8 pins" : "R7 pins"),
                        64'(pin_active), 64'(exp_vec(ph, exp_view(mode, d, 0, 0), 1)));
                end
                @(negedge clk);
                chk("R3 pulse ends", 64'(frame_start), 0);
                chk("R2 hold", 64'(phase_idx), 64'(ph));
            end
        end

        // R4: runtime write visible next cycle
        restart(3, 0);
        tick(); tick(); ph = 2;
        wr(2, 8'h04);
        chk("R4 write", 64'(pin_active), 64'(exp_vec(2, 0, 1)));
        wr(2, 8'hFB);
        chk("R4 write clear", 64'(pin_active), 64'(exp_vec(2, 0, 1)));

        // R6: disabling drops pins in the same cycle
        ctrl_en = 0;
        #1;
        chk("R6 immediate", 64'(pin_active), 0);
        @(negedge clk);
        chk("R6 phase zero", 64'(phase_idx), 0);

        // R9 R10: blink mode 0, rate 0 (8-cycle halves)
        restart(1, 0);
        blink_rate = 0; blink_mode = 0; blink_en = 1;
        repeat (7) @(negedge clk);
        chk("R9 still shown", 64'(pin_active), 64'(exp_vec(ph, 0, 1)));
        @(negedge clk);
        chk("R9 R10 hidden blank", 64'(pin_active), 64'(exp_vec(ph, 2, 1)));
        repeat (7) @(negedge clk);
        chk("R9 still hidden", 64'(pin_active), 64'(exp_vec(ph, 2, 1)));
        @(negedge clk);
        chk("R9 shown again", 64'(pin_active), 64'(exp_vec(ph, 0, 1)));

        // R10: blink mode 1 swaps in alternate view
        blink_en = 0;
        @(negedge clk);
        blink_mode = 1; blink_en = 1;
        repeat (8) @(negedge clk);
        chk("R10 hidden alt", 64'(pin_active), 64'(exp_vec(ph, 1, 1)));

        // R11: clearing blink restores immediately
        blink_en = 0;
        #1;
        chk("R11 restore", 64'(pin_active), 64'(exp_vec(ph, 0, 1)));
        @(negedge clk);

        // R9: rate 1 doubles half period
        blink_rate = 1; blink_mode = 0; blink_en = 1;
        repeat (15) @(negedge clk);
        chk("R9 rate1 shown", 64'(pin_active), 64'(exp_vec(ph, 0, 1)));
        @(negedge clk);
        chk("R9 rate1 hidden", 64'(pin_active), 64'(exp_vec(ph, 2, 1)));
        blink_en = 0;
        @(negedge clk);

        // R10: alternate blink with more than 4 phases falls back to blank
        restart(5, 0);
        blink_rate = 0; blink_mode = 1; blink_en = 1;
        repeat (8) @(negedge clk);
        chk("R10 fallback blank", 64'(pin_active), 64'(exp_vec(ph, 2, 1)));
        blink_en = 0;
        @(negedge clk);

        // R2 R9 collision: tick on the edge the blink half expires
        restart(1, 0);
        blink_mode = 0; blink_en = 1;
        repeat (7) @(negedge clk);
        tick();
        ph = 1;
        chk("R2 collision phase", 64'(phase_idx), 1);
        chk("R9 collision pins", 64'(pin_active), 64'(exp_vec(ph, 2, 1)));
        blink_en = 0;
        @(negedge clk);

        finish_run();
    end
endmodule